// File: doc/BRIEF.md
# Byte-Register Target on a Two-Wire Serial Bus

This block lets an external bus master reach a small bank of byte-wide registers over a two-wire serial bus (SCL clock, SDA data). SDA is open drain. The block models it as an output enable: when `sda_oe` is high the pad pulls the line low, and when it is low the line is released.

A write transaction carries a register pointer and then any number of data bytes, which land at consecutive addresses. A read can start in either of two ways:

- After a pointer write, the master sends a repeated start and then a read-mode address byte.
- The master sends a read-mode address byte straight away. The transfer then picks up at the location just after the last one touched.

The pointer is kept between transactions. It rolls over at the top of the address space.

The register bank itself sits outside the block. It is reached through a single port: a combinational read of `reg_rdata` at `reg_addr`, and a one-cycle write strobe. Both bus lines are resynchronised to the system clock, which must run well above the SCL rate.

Top module: `regbus_i2c_target`

## Requirements
- R1: While reset is held, and until bus activity begins after it, `sda_oe` and `reg_we` are both 0.
- R2: The address byte carries 7 address bits MSB first, then the direction bit (1 = read). It is acknowledged only when its address bits equal `dev_addr`. On a mismatch the target leaves SDA released in the acknowledge slot and in every later bit, and writes nothing, until the next start.
- R3: In a write transaction the first byte after the address byte loads the pointer (its low ADDR_W bits). Each later byte gives one `reg_we` pulse, one cycle long, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. The pointer then advances by one.
- R4: The target pulls SDA low in the acknowledge slot after a matching address byte, after the pointer byte, and after every data byte it receives.
- R5: A repeated start after a pointer write, followed by a read-mode address byte, makes the target transmit bytes MSB first. They come from the pointer just written and then from successive addresses.
- R6: A read that opens directly with a read-mode address byte starts at the address one past the last register written or read.
- R7: A master acknowledge of 0 asks for the next byte. A master acknowledge of 1 makes the target release SDA and drive nothing until a start or stop, even if SCL keeps toggling.
- R8: The pointer wraps from 2^ADDR_W-1 to 0, on writes and on reads alike.
- R9: A start or stop arriving part-way through a byte discards the partial byte without writing it. The next transfer is framed from its first bit.
- R10: The target only begins pulling SDA low while SCL is low, so the level it presents stays constant through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_addr | input | 7 | Bus address the target answers to |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | ADDR_W | Register address (current pointer) |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
The assertions rely on the master obeying the bus rules:

- SDA changes only while SCL is low, except to form a start or a stop.
- Every SCL phase lasts several system clocks, so that no two line events fall within one synchronizer delay of each other.
- The master never creates a start or stop while the target is pulling SDA low.

The bench master holds each SCL quarter-period for eight clocks and moves SDA only after SCL has been low for a full quarter. It issues starts and stops only while the target should be silent, so every stimulus stays inside these assumptions.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  // Byte engine phases
  typedef enum logic [2:0] {
    ST_IDLE,     // bus free, nothing addressed
    ST_ADDR,     // shifting in the address byte
    ST_ADDR_ACK, // driving acknowledge for our address
    ST_RX,       // shifting in a pointer or data byte
    ST_RX_ACK,   // driving acknowledge for a received byte
    ST_TX,       // shifting a byte out to the master
    ST_TX_ACK,   // listening to the master acknowledge
    ST_WAIT      // deaf until the next start or stop
  } tgt_state_e;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  // Idle bus level is high, so every stage resets to ones.
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '1;
          else        stage_q[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '1;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2ct_linemon.sv
module i2ct_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_prev_q;
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s &  scl_prev_q;
  // SDA edges are only meaningful while SCL stays high across both samples.
  assign start_det = scl_s & scl_prev_q &  sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q &  sda_s;

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        reg_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [7:0]        reg_wdata
);

  localparam int unsigned CNT_W    = $clog2(BYTE_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  tgt_state_e        st_q,    st_n;
  logic [CNT_W-1:0]  cnt_q,   cnt_n;
  logic [7:0]        sh_q,    sh_n;     // receive shifter
  logic [7:0]        tx_q,    tx_n;     // transmit shifter
  logic              rw_q,    rw_n;     // direction of current transfer
  logic              pph_q,   pph_n;    // next received byte is the pointer
  logic              inc_q,   inc_n;    // pointer advance owed after a write
  logic              mnack_q, mnack_n;  // master acknowledge level
  logic [ADDR_W-1:0] ptr_q,   ptr_n;    // persistent register pointer
  logic              we_q,    we_n;
  logic [7:0]        wd_q,    wd_n;

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    rw_n    = rw_q;
    pph_n   = pph_q;
    inc_n   = inc_q;
    mnack_n = mnack_q;
    ptr_n   = ptr_q;
    we_n    = 1'b0;
    wd_n    = wd_q;

    if (start_det) begin
      // Start (or repeated start) restarts framing, even mid-byte.
      st_n  = ST_ADDR;
      cnt_n = '0;
    end else if (stop_det) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
        end

        ST_ADDR: begin
          if (scl_rise && (cnt_q < CNT_FULL)) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + CNT_ONE;
          end
          if (scl_fall && (cnt_q == CNT_FULL)) begin
            cnt_n = '0;
            if (sh_q[7:1] == dev_addr) begin
              st_n  = ST_ADDR_ACK;
              rw_n  = sh_q[0];
              pph_n = 1'b1;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              st_n  = ST_TX;
              tx_n  = reg_rdata;
              ptr_n = ptr_q + PTR_ONE;
            end else begin
              st_n = ST_RX;
            end
          end
        end

        ST_RX: begin
          if (scl_rise && (cnt_q < CNT_FULL)) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + CNT_ONE;
          end
          if (scl_fall && (cnt_q == CNT_FULL)) begin
            cnt_n = '0;
            st_n  = ST_RX_ACK;
            if (pph_q) begin
              ptr_n = sh_q[ADDR_W-1:0];
              pph_n = 1'b0;
            end else begin
              we_n  = 1'b1;
              wd_n  = sh_q;
              inc_n = 1'b1;
            end
          end
        end

        ST_RX_ACK: begin
          if (scl_fall) begin
            st_n = ST_RX;
            if (inc_q) begin
              ptr_n = ptr_q + PTR_ONE;
              inc_n = 1'b0;
            end
          end
        end

        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_n  = ST_TX_ACK;
              cnt_n = '0;
            end else begin
              tx_n  = {tx_q[6:0], 1'b0};
              cnt_n = cnt_q + CNT_ONE;
            end
          end
        end

        ST_TX_ACK: begin
          if (scl_rise) mnack_n = sda_s;
          if (scl_fall) begin
            if (!mnack_q) begin
              st_n  = ST_TX;
              tx_n  = reg_rdata;
              ptr_n = ptr_q + PTR_ONE;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end

        ST_WAIT: begin
        end

        default: st_n = ST_IDLE;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      pph_q   <= 1'b0;
      inc_q   <= 1'b0;
      mnack_q <= 1'b1;
      ptr_q   <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      rw_q    <= rw_n;
      pph_q   <= pph_n;
      inc_q   <= inc_n;
      mnack_q <= mnack_n;
      ptr_q   <= ptr_n;
      we_q    <= we_n;
      wd_q    <= wd_n;
    end
  end

  assign sda_oe    = (st_q == ST_ADDR_ACK) || (st_q == ST_RX_ACK) ||
                     ((st_q == ST_TX) && !tx_q[7]);
  assign reg_addr  = ptr_q;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;

endmodule

// File: rtl/regbus_i2c_target.sv
module regbus_i2c_target #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [1:0] lines_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;

  i2ct_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({scl_in, sda_in}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2ct_linemon u_linemon (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2ct_engine #(
    .ADDR_W (ADDR_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dev_addr  (dev_addr),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata)
  );

endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr
);

  // R3
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3
  we_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> $stable(reg_addr));

  // R4
  we_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);

  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

bind regbus_i2c_target i2ct_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr)
);

// File: tb/regbus_i2c_target_tb.sv
module regbus_i2c_target_tb;

  localparam int AW   = 4;
  localparam int NREG = 1 << AW;
  localparam logic [6:0] MY_ADDR = 7'h32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_m, sda_m;
  logic          sda_oe;
  logic [AW-1:0] reg_addr;
  logic          reg_we;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  wire           sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk; // 125 MHz

  regbus_i2c_target #(.ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_addr  (MY_ADDR),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // Register bank outside the block
  logic [7:0] rf [NREG];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'(i * 37 + 5);
    end else if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = rf[reg_addr];

  // Reference model
  logic [7:0] mdl [NREG];
  int         mptr;
  int         exp_a[$];
  int         exp_d[$];
  int         checks = 0;
  int         errors = 0;
  bit         quiet  = 1'b0;
  bit         done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (quiet) chk(!sda_oe, "R2/R7 silent target", int'(sda_oe), 0);
      if (reg_we) begin
        if (exp_a.size() == 0) begin
          chk(1'b0, "R3/R9 unexpected write", int'(reg_addr), -1);
        end else begin
          chk(int'(reg_addr) == exp_a[0], "R3 write address", int'(reg_addr), exp_a[0]);
          chk(int'(reg_wdata) == exp_d[0], "R3 write data", int'(reg_wdata), exp_d[0]);
          void'(exp_a.pop_front());
          void'(exp_d.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  task automatic qp();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    quiet = 1'b1;
    sda_m = 1'b1; qp();
    scl_m = 1'b1; qp();
    sda_m = 1'b0; qp();
    scl_m = 1'b0; qp();
  endtask

  task automatic bus_stop();
    quiet = 1'b1;
    sda_m = 1'b0; qp();
    scl_m = 1'b1; qp();
    sda_m = 1'b1; qp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    quiet = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qp();
      scl_m = 1'b1; qp(); qp();
      scl_m = 1'b0; qp();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    quiet = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qp();
      scl_m = 1'b1; qp(); qp();
      scl_m = 1'b0;
      if (i == 0) quiet = 1'b0;
      qp();
    end
    sda_m = 1'b1; qp();
    scl_m = 1'b1; qp();
    ack = !sda_line; qp();
    scl_m = 1'b0; qp();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic early;
    quiet = 1'b0;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qp();
      scl_m = 1'b1;
      repeat (4) @(negedge clk);
      early = sda_line;
      repeat (4) @(negedge clk);
      b[i] = sda_line;
      chk(early == b[i], "R10 SDA steady while SCL high", int'(early), int'(b[i]));
      qp();
      scl_m = 1'b0;
    end
    qp();
    sda_m = mack; qp();
    scl_m = 1'b1; qp(); qp();
    scl_m = 1'b0; qp();
    sda_m = 1'b1;
  endtask

  task automatic addr_byte(input logic [6:0] a, input bit rd, input bit exp_ack, input string req);
    bit ack;
    send_byte({a, rd}, ack);
    chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
  endtask

  task automatic ptr_byte(input int p);
    bit ack;
    mptr = p % NREG;
    send_byte(8'(p), ack);
    chk(ack, "R4 pointer ack", int'(ack), 1);
  endtask

  task automatic data_byte(input logic [7:0] d, input string req);
    bit ack;
    exp_a.push_back(mptr);
    exp_d.push_back(int'(d));
    mdl[mptr] = d;
    mptr = (mptr + 1) % NREG;
    send_byte(d, ack);
    chk(ack, req, int'(ack), 1);
  endtask

  task automatic read_byte(input bit mack, input string req);
    logic [7:0] b;
    recv_byte(mack, b);
    chk(b == mdl[mptr], req, int'(b), int'(mdl[mptr]));
    mptr = (mptr + 1) % NREG;
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    chk(exp_a.size() == 0, req, exp_a.size(), 0);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'(i * 37 + 5);
    mptr  = 0;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    repeat (6) @(negedge clk);
    chk(!sda_oe, "R1 sda_oe in reset", int'(sda_oe), 0);
    chk(!reg_we, "R1 reg_we in reset", int'(reg_we), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!sda_oe && !reg_we, "R1 idle after reset", int'({sda_oe, reg_we}), 0);

    // Pointer plus a burst of writes
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R2/R4 address ack");
    ptr_byte(3);
    data_byte(8'hA1, "R4 data ack");
    data_byte(8'hB2, "R3 second data ack");
    data_byte(8'hC3, "R3 third data ack");
    bus_stop();
    drain("R3 all writes seen");

    // Pointer write, repeated start, read
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R4 address ack");
    ptr_byte(4);
    bus_start();
    addr_byte(MY_ADDR, 1'b1, 1'b1, "R5 read address ack");
    read_byte(1'b0, "R5 first byte from pointer");
    read_byte(1'b1, "R5 second byte");
    bus_stop();

    // Read with no pointer phase
    bus_start();
    addr_byte(MY_ADDR, 1'b1, 1'b1, "R6 read address ack");
    read_byte(1'b1, "R6 resume after last read");
    bus_stop();

    // Writes across the top of the space, then resume read
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R4 address ack");
    ptr_byte(NREG - 2);
    data_byte(8'h5E, "R8 write before wrap");
    data_byte(8'h6F, "R8 write at top");
    data_byte(8'h70, "R8 write wrapped to 0");
    bus_stop();
    drain("R8 wrapped writes seen");
    bus_start();
    addr_byte(MY_ADDR, 1'b1, 1'b1, "R6 read address ack");
    read_byte(1'b0, "R6 resume after last write");
    read_byte(1'b1, "R6 second resumed byte");
    bus_stop();

    // Read across the top of the space
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R4 address ack");
    ptr_byte(NREG - 1);
    bus_start();
    addr_byte(MY_ADDR, 1'b1, 1'b1, "R5 read address ack");
    read_byte(1'b0, "R8 read at top");
    read_byte(1'b1, "R8 read wrapped to 0");
    // After the NACK the target must stay silent even if SCL keeps running
    send_byte(8'hFF, ack);
    chk(!ack, "R7 no drive after master NACK", int'(ack), 0);
    bus_stop();

    // Foreign address: ignored until the next start
    bus_start();
    addr_byte(MY_ADDR ^ 7'h01, 1'b0, 1'b0, "R2 foreign address nack");
    send_byte(8'h00, ack);
    chk(!ack, "R2 ignored pointer", int'(ack), 0);
    send_byte(8'h99, ack);
    chk(!ack, "R2 ignored data", int'(ack), 0);
    bus_stop();
    drain("R2 nothing written");
    bus_start();
    addr_byte(MY_ADDR, 1'b1, 1'b1, "R2 read address ack");
    read_byte(1'b1, "R2 pointer untouched by foreign transfer");
    bus_stop();

    // Stop in the middle of a data byte
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R4 address ack");
    ptr_byte(8);
    send_bits(8'hE7, 4);
    bus_stop();
    drain("R9 partial byte dropped");
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R9 framing restored");
    ptr_byte(9);
    data_byte(8'h33, "R9 write after abort");
    bus_stop();
    drain("R9 write after abort seen");

    // Start in the middle of a data byte
    bus_start();
    addr_byte(MY_ADDR, 1'b0, 1'b1, "R4 address ack");
    ptr_byte(10);
    send_bits(8'h0F, 3);
    bus_start();
    addr_byte(MY_ADDR, 1'b1, 1'b1, "R9 read after mid-byte start");
    read_byte(1'b1, "R9 read from pointer kept");
    bus_stop();
    drain("R9 no write from cut byte");

    for (int i = 0; i < NREG; i++)
      chk(rf[i] == mdl[i], "R3 register bank contents", int'(rf[i]), int'(mdl[i]));

    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule